// File: doc/BRIEF.md
# Serial Audio Frame Collector

The collector takes a stereo serial audio stream made of a bit clock, a word clock and one data line. It rebuilds 16-bit samples and joins each left sample with the right sample that follows it. Each joined pair is written as one 32-bit word into a frame memory.

Once the frame memory holds a full frame of pairs, the collector reads the frame back in address order, one word per system clock. The left sample comes out as the real part and the right sample as the imaginary part, with a valid strobe, so a transform engine can take the words directly.

Pairs that arrive while a frame is being streamed out go into a small side buffer. When the stream ends, the buffer is emptied into the memory as the first words of the next frame. The controller steps through four states in turn: store, flush, buffer and drain.

Top module: `audio_frame_collector`

## Requirements
- R1: Data is sampled on rising bit-clock edges, MSB first, with 16 bits in each word-clock slot. A slot with the word clock low carries the left sample and a slot with it high carries the right sample. A pair is committed on the first rising bit-clock edge that sees the word clock low after a right slot.
- R2: A right slot that has no left slot since the previous commit is discarded and produces no memory word. The first rising bit-clock edge after reset only records the word-clock level.
- R3: Pairs are written to frame addresses 0 to FRAME_PAIRS-1 in arrival order. Streaming starts after the FRAME_PAIRS-th write. The stream then presents every address once, in ascending order, in FRAME_PAIRS consecutive cycles with valid_o high.
- R4: done_o is high for exactly one cycle per frame, in the same cycle as the last valid word of that frame.
- R5: Pairs that arrive during streaming are kept in the side buffer and become the first words of the next frame, in arrival order. No pair is lost while the buffer does not fill.
- R6: A pair that arrives while the side buffer is full and not being read is dropped, and overflow_o is set. overflow_o stays set until reset.
- R7: After reset, valid_o, done_o, overflow_o, real_o and imag_o are all zero.
- R8: real_o carries the left sample (bits 31:16 of the stored word) and imag_o carries the right sample (bits 15:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_clk_i | input | 1 | Serial bit clock (asynchronous) |
| word_clk_i | input | 1 | Left/right word clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| real_o | output | SAMPLE_W | Streamed left sample |
| imag_o | output | SAMPLE_W | Streamed right sample |
| valid_o | output | 1 | Streamed word valid |
| done_o | output | 1 | One-cycle pulse on the last word of a frame |
| overflow_o | output | 1 | Sticky side-buffer overflow flag |

## Verification
The stream opens with a lone right slot. A receiver that committed it would shift every later word by one position and corrupt all frames. The bit clock runs at the slowest permitted ratio, so two pairs land during every 256-word flush. A wrong drain would lose these pairs, write them out of order or put them at the wrong addresses, and each of those shows up as a miscompare at the start of the next frame. A second instance, with a one-entry buffer, must drop the second of those pairs and raise a flag that stays set. The default instance, with more room, must never raise it. Every streamed word is compared, along with the position of each done pulse.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {
    ST_STORE  = 2'd0,
    ST_FLUSH  = 2'd1,
    ST_BUFFER = 2'd2,
    ST_DRAIN  = 2'd3
  } afc_state_e;
endpackage

// File: rtl/afc_serial_rx.sv
module afc_serial_rx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_clk_i,
  input  logic                word_clk_i,
  input  logic                sdata_i,
  output logic                pair_valid_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic bclk_s1, bclk_s2, bclk_s3;
  logic ws_s1, ws_s2, sd_s1, sd_s2;
  logic ws_prev_q, primed_q, left_ok_q, pair_v_q;
  logic [SAMPLE_W-1:0] shift_q, left_q, right_q;
  logic bclk_rise;

  assign bclk_rise = bclk_s2 & ~bclk_s3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_s1 <= 1'b0; bclk_s2 <= 1'b0; bclk_s3 <= 1'b0;
      ws_s1 <= 1'b0; ws_s2 <= 1'b0; sd_s1 <= 1'b0; sd_s2 <= 1'b0;
      ws_prev_q <= 1'b0; primed_q <= 1'b0; left_ok_q <= 1'b0; pair_v_q <= 1'b0;
      shift_q <= '0; left_q <= '0; right_q <= '0;
    end else begin
      bclk_s1 <= bit_clk_i;  bclk_s2 <= bclk_s1; bclk_s3 <= bclk_s2;
      ws_s1   <= word_clk_i; ws_s2   <= ws_s1;
      sd_s1   <= sdata_i;    sd_s2   <= sd_s1;
      pair_v_q <= 1'b0;
      if (bclk_rise) begin
        shift_q   <= {shift_q[SAMPLE_W-2:0], sd_s2};
        ws_prev_q <= ws_s2;
        primed_q  <= 1'b1;
        // slot boundary: shift_q holds the finished word of the previous slot
        if (primed_q && (ws_s2 != ws_prev_q)) begin
          if (!ws_prev_q) begin
            left_q    <= shift_q;
            left_ok_q <= 1'b1;
          end else if (left_ok_q) begin
            right_q   <= shift_q;
            left_ok_q <= 1'b0;
            pair_v_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign pair_valid_o = pair_v_q;
  assign left_o       = left_q;
  assign right_o      = right_q;
endmodule

// File: rtl/afc_side_fifo.sv
module afc_side_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     store_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) store_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = store_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
endmodule

// File: rtl/afc_frame_ram.sv
module afc_frame_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic                     re_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/audio_frame_collector.sv
module audio_frame_collector
  import afc_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_PAIRS = 256,
  parameter int BUF_DEPTH   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_clk_i,
  input  logic                word_clk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] real_o,
  output logic [SAMPLE_W-1:0] imag_o,
  output logic                valid_o,
  output logic                done_o,
  output logic                overflow_o
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int ADDR_W = $clog2(FRAME_PAIRS);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(FRAME_PAIRS - 1);

  afc_state_e state_q, state_d;
  logic                pair_v;
  logic [SAMPLE_W-1:0] left_s, right_s;
  logic [WORD_W-1:0]   pair_word, fifo_dout, mem_wdata, mem_rdata;
  logic                fifo_push, fifo_pop, fifo_empty, fifo_full, fifo_accept;
  logic                mem_we, rd_en;
  logic [ADDR_W-1:0]   wr_addr_q, rd_addr_q;
  logic                valid_q, done_q, ovf_q;

  afc_serial_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk_i, .rst_ni, .bit_clk_i, .word_clk_i, .sdata_i,
    .pair_valid_o(pair_v), .left_o(left_s), .right_o(right_s)
  );

  assign pair_word   = {left_s, right_s};
  assign fifo_accept = fifo_push && (!fifo_full || fifo_pop);

  afc_side_fifo #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_accept), .data_i(pair_word),
    .pop_i(fifo_pop), .data_o(fifo_dout),
    .empty_o(fifo_empty), .full_o(fifo_full)
  );

  afc_frame_ram #(.W(WORD_W), .DEPTH(FRAME_PAIRS)) u_ram (
    .clk_i, .rst_ni,
    .we_i(mem_we), .waddr_i(wr_addr_q), .wdata_i(mem_wdata),
    .re_i(rd_en), .raddr_i(rd_addr_q), .rdata_o(mem_rdata)
  );

  always_comb begin
    state_d   = state_q;
    mem_we    = 1'b0;
    mem_wdata = pair_word;
    fifo_push = 1'b0;
    fifo_pop  = 1'b0;
    rd_en     = 1'b0;
    unique case (state_q)
      ST_STORE: begin
        mem_we = pair_v;
        if (pair_v && wr_addr_q == ADDR_LAST) state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        rd_en     = 1'b1;
        fifo_push = pair_v;
        if (rd_addr_q == ADDR_LAST) state_d = ST_BUFFER;
      end
      ST_BUFFER: begin
        fifo_push = pair_v;
        state_d   = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!fifo_empty) begin
          fifo_pop  = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = fifo_dout;
          fifo_push = pair_v;
        end else begin
          mem_we  = pair_v;
          state_d = ST_STORE;
        end
      end
      default: state_d = ST_STORE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_STORE;
      wr_addr_q <= '0;
      rd_addr_q <= '0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mem_we) wr_addr_q <= (wr_addr_q == ADDR_LAST) ? '0 : wr_addr_q + 1'b1;
      if (rd_en)  rd_addr_q <= (rd_addr_q == ADDR_LAST) ? '0 : rd_addr_q + 1'b1;
      valid_q <= rd_en;
      done_q  <= rd_en && (rd_addr_q == ADDR_LAST);
      if (fifo_push && !fifo_accept) ovf_q <= 1'b1;
    end
  end

  assign real_o     = mem_rdata[WORD_W-1:SAMPLE_W];
  assign imag_o     = mem_rdata[SAMPLE_W-1:0];
  assign valid_o    = valid_q;
  assign done_o     = done_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/afc_checker.sv
module afc_checker
  import afc_pkg::*;
#(
  parameter int FRAME_PAIRS = 256,
  parameter int BUF_DEPTH   = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       done_i,
  input logic       overflow_i,
  input logic       mem_we_i,
  input afc_state_e state_i
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (valid_i) run_q <= run_q + 1;
    else              run_q <= '0;
  end

  initial assert_buf_smaller_R5: assert (BUF_DEPTH < FRAME_PAIRS);

  assert_done_with_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> valid_i);
  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_i |=> overflow_i);
  assert_run_length_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && $past(valid_i)) |-> (run_q == 32'(FRAME_PAIRS)));
  assert_valid_from_flush_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($past(state_i) == ST_FLUSH));
  assert_no_write_in_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FLUSH) |-> !mem_we_i);
endmodule

bind audio_frame_collector afc_checker #(
  .FRAME_PAIRS(FRAME_PAIRS), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_o), .done_i(done_o),
  .overflow_i(overflow_o), .mem_we_i(mem_we), .state_i(state_q)
);

// File: tb/audio_frame_collector_bench.sv
`timescale 1ns/1ps
module audio_frame_collector_bench;
  localparam int SW     = 16;
  localparam int NPAIR  = 256;
  localparam int FRAMES = 3;
  localparam int TOTAL  = NPAIR * FRAMES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b1, sdata = 1'b0;
  logic [SW-1:0] re_a, im_a, re_b, im_b;
  logic v_a, d_a, o_a, v_b, d_b, o_b;

  int checks = 0, fails = 0, cycles = 0;
  int a_idx = 0, b_idx = 0, a_dones = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  audio_frame_collector #(.SAMPLE_W(SW), .FRAME_PAIRS(NPAIR), .BUF_DEPTH(4)) u_audio_frame_collector (
    .clk_i(clk), .rst_ni(rst_n), .bit_clk_i(bclk), .word_clk_i(wclk), .sdata_i(sdata),
    .real_o(re_a), .imag_o(im_a), .valid_o(v_a), .done_o(d_a), .overflow_o(o_a));

  audio_frame_collector #(.SAMPLE_W(SW), .FRAME_PAIRS(NPAIR), .BUF_DEPTH(1)) u_audio_frame_collector_small (
    .clk_i(clk), .rst_ni(rst_n), .bit_clk_i(bclk), .word_clk_i(wclk), .sdata_i(sdata),
    .real_o(re_b), .imag_o(im_b), .valid_o(v_b), .done_o(d_b), .overflow_o(o_b));

  function automatic logic [2*SW-1:0] exp_pair(input int i);
    logic [SW-1:0] l, r;
    l = SW'(i * 37 + 5);
    r = SW'(i * 91) ^ 16'hA5C3;
    return {l, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic slot(input logic lr, input logic [SW-1:0] v);
    for (int b = SW - 1; b >= 0; b--) begin
      wclk = lr; sdata = v[b];
      #10 bclk = 1'b1;
      #10 bclk = 1'b0;
    end
  endtask

  // output monitors, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (v_a) begin
        // R1 R3 R5 R8: word order and lane mapping, buffered pairs included
        check({re_a, im_a} == exp_pair(a_idx), "R3/R5/R8 stream word", {re_a, im_a}, exp_pair(a_idx));
        // R4: done on last word only
        check(d_a == ((a_idx % NPAIR) == NPAIR - 1), "R4 done position", 32'(d_a), 32'((a_idx % NPAIR) == NPAIR - 1));
        if (d_a) a_dones++;
        a_idx++;
      end else if (d_a) begin
        check(1'b0, "R4 done without valid", 32'd1, 32'd0);
      end
      if (v_b && b_idx < NPAIR) begin
        check({re_b, im_b} == exp_pair(b_idx), "R3 small-buffer frame word", {re_b, im_b}, exp_pair(b_idx));
        b_idx++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1'b1;
        fails++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    check(!v_a && !d_a && !o_a, "R7 flags after reset", {29'd0, v_a, d_a, o_a}, 32'd0);
    check({re_a, im_a} == 32'd0, "R7 data after reset", {re_a, im_a}, 32'd0);
    // R2: lone right slot must not produce a pair
    slot(1'b1, 16'hBEEF);
    for (int i = 0; i < TOTAL + 2; i++) begin
      slot(1'b0, exp_pair(i)[2*SW-1:SW]);
      slot(1'b1, exp_pair(i)[SW-1:0]);
    end
    slot(1'b0, 16'h0000);
    repeat (600) @(negedge clk);
    // R1 R2 R3 R5: every frame streamed complete and in order
    check(a_idx == TOTAL, "R3/R5 streamed word count", 32'(a_idx), 32'(TOTAL));
    check(a_dones == FRAMES, "R4 done pulse count", 32'(a_dones), 32'(FRAMES));
    check(b_idx == NPAIR, "R3 small-buffer first frame count", 32'(b_idx), 32'(NPAIR));
    // R6: overflow only where the buffer is too small, and it stays set
    check(o_a == 1'b0, "R6 no overflow with deep buffer", 32'(o_a), 32'd0);
    check(o_b == 1'b1, "R6 sticky overflow with one-entry buffer", 32'(o_b), 32'd1);
    check(!v_a && !d_a, "R3 idle after final frame", {30'd0, v_a, d_a}, 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule